// File: doc/BRIEF.md
# Graphics Front-End Register Bank

This block is the 32-bit register bank that sits between a host bus and the front end of a graphics pipeline. The host issues reads and writes by byte address. Each write carries a per-bit mask, and only the masked bit positions of the stored word change. Every implemented word can be read back, with one cycle of latency.

Some register indices also drive side-band fields for the rest of the pipeline. These fields are the colour and depth buffer base addresses, the colour format, the framebuffer width and height, the vertex attribute count and fixed-attribute mask, a boolean uniform word, a shader entry point, and one offset, size and component-count set for each vertex attribute. Writing a non-zero value to a trigger index produces a one-cycle draw strobe or a shader-finalize strobe. The side-band decoding always works on the full write data and ignores the mask. Rendering and shader execution happen elsewhere.

The window is parameterised. By default it spans 0x1EF01000 up to but not including 0x1EF01C00, and it implements 64 words with 4 attribute descriptors.

Top module: `gpu_regbank`

## Requirements
- R1: An access whose byte address lies outside [0x1EF01000, 0x1EF01C00) has no effect on stored words, side-band outputs or the error flag. A read of such an address returns 0.
- R2: The word index is (address − 0x1EF01000) >> 2. A write to an implemented index stores (old & ~mask) | (data & mask). When `bus_rd` is high, `rd_data` presents that index's stored word after the next clock edge.
- R3: A write of non-zero data to index 2 raises `draw_pulse` for exactly one cycle after the edge, with `draw_indexed` low. The same write to index 3 raises `draw_pulse` with `draw_indexed` high. A zero write to either index raises neither output.
- R4: A write to index 4 sets `attr_total` to data[31:28]+1 and `fixed_mask` to data[27:16].
- R5: A write to index 8 sets `color_base` to data[27:0]<<3. A write to index 10 sets `depth_base` to data[27:0]<<3. A write to index 9 sets `color_fmt` to data[18:16].
- R6: A write to index 11 sets `fb_width` to data[10:0] and `fb_height` to data[21:12]+1.
- R7: Indices 32 to 43 form 4 descriptor groups. The group number is (index−32)/3 and the slot is (index−32)%3. Slot 0 sets that group's 28-bit offset to data[27:0]. Slot 2 sets its size to data[23:16] and its component count to data[31:28]. Group g occupies bits [g*28 +: 28], [g*8 +: 8] and [g*4 +: 4] of the flattened outputs.
- R8: A write to index 16 sets `bool_uniform` to data[15:0]. A write to index 17 sets `entry_point` to data[15:0].
- R9: A non-zero write to index 18 raises `finalize_pulse` for one cycle. A zero write does not.
- R10: A read or write inside the window whose index is 64 or more sets `err_flag`, which stays set until reset. The access changes no state, and such a read returns 0.
- R11: After reset every stored word, every side-band output, both pulses and `err_flag` are 0.
- R12: Side-band fields decode the unmasked write data. A write with an all-zero mask still updates them while the stored word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write mask |
| rd_data | output | 32 | Registered read data |
| err_flag | output | 1 | Sticky bad-index flag |
| draw_pulse | output | 1 | Draw trigger strobe |
| draw_indexed | output | 1 | Indexed-draw qualifier for draw_pulse |
| finalize_pulse | output | 1 | Shader-upload finalize strobe |
| attr_total | output | 5 | Total vertex attribute count |
| fixed_mask | output | 12 | Fixed-attribute mask |
| color_base | output | 31 | Colour buffer byte base |
| depth_base | output | 31 | Depth buffer byte base |
| color_fmt | output | 3 | Colour format code |
| fb_width | output | 11 | Framebuffer width |
| fb_height | output | 11 | Framebuffer height |
| bool_uniform | output | 16 | Boolean uniform bits |
| entry_point | output | 16 | Shader entry point |
| attr_offset | output | 112 | Per-group 28-bit offsets, flattened |
| attr_size | output | 32 | Per-group 8-bit sizes, flattened |
| attr_comps | output | 16 | Per-group 4-bit component counts, flattened |

## Verification
The bench sends an access just above the window whose low offset bits alias the framebuffer index. A decoder that checks only the low address bits would then change `fb_width`. An all-zero-mask write to a decoded index checks R12: a design that applies the mask to the side-band data would leave the field stale, and one that skips the mask would corrupt the stored word. Zero writes to the trigger indices must produce no strobe, and `draw_indexed` must separate the two draw indices. The bench also reaches index 64, one past the last implemented word. A decoder with an off-by-one limit would accept that access instead of setting `err_flag`, and a missing guard would return a stale read value instead of 0.

// File: rtl/gpu_regbank_pkg.sv
package gpu_regbank_pkg;
   localparam int unsigned IX_DRAW_ARRAYS = 2;
   localparam int unsigned IX_DRAW_ELEMS  = 3;
   localparam int unsigned IX_ATTR_FMT    = 4;
   localparam int unsigned IX_COLOR_BASE  = 8;
   localparam int unsigned IX_COLOR_FMT   = 9;
   localparam int unsigned IX_DEPTH_BASE  = 10;
   localparam int unsigned IX_FB_DIMS     = 11;
   localparam int unsigned IX_BOOL_UNI    = 16;
   localparam int unsigned IX_ENTRY       = 17;
   localparam int unsigned IX_XFER_END    = 18;
   localparam int unsigned IX_ATTR_FIRST  = 32;

   localparam int unsigned ATTR_SLOTS = 3;
   localparam int unsigned OFS_W      = 28;
   localparam int unsigned SIZE_W     = 8;
   localparam int unsigned COMP_W     = 4;

   typedef struct packed {
      logic [10:0] width;
      logic [10:0] height;
   } fb_dims_t;

   function automatic logic [30:0] byte_base(input logic [27:0] units);
      return {units, 3'b000};
   endfunction
endpackage

// File: rtl/gpu_regbank_dec.sv
module gpu_regbank_dec #(
   parameter logic [31:0] BASE_ADDR = 32'h1EF0_1000,
   parameter logic [31:0] WIN_BYTES = 32'h0000_0C00,
   parameter int unsigned NUM_REGS  = 64,
   parameter int unsigned IDX_W     = 6
) (
   input  logic [31:0]      addr,
   output logic             in_win,
   output logic             in_range,
   output logic [IDX_W-1:0] idx
);
   localparam logic [31:0] END_ADDR = BASE_ADDR + WIN_BYTES;

   logic [31:0] off;

   always_comb begin
      off      = addr - BASE_ADDR;
      in_win   = (addr >= BASE_ADDR) && (addr < END_ADDR);
      in_range = in_win && ((off >> 2) < 32'(NUM_REGS));
      idx      = off[IDX_W+1:2];
   end
endmodule

// File: rtl/gpu_regbank_store.sv
module gpu_regbank_store #(
   parameter int unsigned NUM_REGS = 64,
   parameter int unsigned IDX_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             re,
   input  logic             hit,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   input  logic [31:0]      wmask,
   output logic [31:0]      rdata
);
   logic [31:0] words [NUM_REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NUM_REGS); i++) words[i] <= '0;
         rdata <= '0;
      end else begin
         if (re) rdata <= hit ? words[idx] : '0;
         if (we && hit) words[idx] <= (words[idx] & ~wmask) | (wdata & wmask);
      end
   end
endmodule

// File: rtl/gpu_regbank_side.sv
module gpu_regbank_side
   import gpu_regbank_pkg::*;
#(
   parameter int unsigned NUM_ATTR = 4,
   parameter int unsigned IDX_W    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr,
   input  logic [IDX_W-1:0]           idx,
   input  logic [31:0]                wdata,
   output logic                       draw_pulse,
   output logic                       draw_indexed,
   output logic                       finalize_pulse,
   output logic [4:0]                 attr_total,
   output logic [11:0]                fixed_mask,
   output logic [30:0]                color_base,
   output logic [30:0]                depth_base,
   output logic [2:0]                 color_fmt,
   output logic [10:0]                fb_width,
   output logic [10:0]                fb_height,
   output logic [15:0]                bool_uniform,
   output logic [15:0]                entry_point,
   output logic [NUM_ATTR*OFS_W-1:0]  attr_offset,
   output logic [NUM_ATTR*SIZE_W-1:0] attr_size,
   output logic [NUM_ATTR*COMP_W-1:0] attr_comps
);
   localparam int unsigned ATTR_LAST = IX_ATTR_FIRST + ATTR_SLOTS*NUM_ATTR;

   logic             nz;
   logic             in_attr;
   logic [IDX_W-1:0] rel, grp, slot;
   fb_dims_t         dims;

   always_comb begin
      nz      = |wdata;
      in_attr = (idx >= IDX_W'(IX_ATTR_FIRST)) && (idx < IDX_W'(ATTR_LAST));
      rel     = idx - IDX_W'(IX_ATTR_FIRST);
      grp     = rel / IDX_W'(ATTR_SLOTS);
      slot    = rel % IDX_W'(ATTR_SLOTS);
      dims.width  = wdata[10:0];
      dims.height = {1'b0, wdata[21:12]} + 11'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         draw_pulse     <= 1'b0;
         draw_indexed   <= 1'b0;
         finalize_pulse <= 1'b0;
         attr_total     <= '0;
         fixed_mask     <= '0;
         color_base     <= '0;
         depth_base     <= '0;
         color_fmt      <= '0;
         fb_width       <= '0;
         fb_height      <= '0;
         bool_uniform   <= '0;
         entry_point    <= '0;
      end else begin
         draw_pulse     <= wr && nz && (idx == IDX_W'(IX_DRAW_ARRAYS) || idx == IDX_W'(IX_DRAW_ELEMS));
         draw_indexed   <= wr && nz && (idx == IDX_W'(IX_DRAW_ELEMS));
         finalize_pulse <= wr && nz && (idx == IDX_W'(IX_XFER_END));
         if (wr) begin
            if (idx == IDX_W'(IX_ATTR_FMT)) begin
               attr_total <= {1'b0, wdata[31:28]} + 5'd1;
               fixed_mask <= wdata[27:16];
            end
            if (idx == IDX_W'(IX_COLOR_BASE)) color_base <= byte_base(wdata[27:0]);
            if (idx == IDX_W'(IX_DEPTH_BASE)) depth_base <= byte_base(wdata[27:0]);
            if (idx == IDX_W'(IX_COLOR_FMT))  color_fmt  <= wdata[18:16];
            if (idx == IDX_W'(IX_FB_DIMS)) begin
               fb_width  <= dims.width;
               fb_height <= dims.height;
            end
            if (idx == IDX_W'(IX_BOOL_UNI)) bool_uniform <= wdata[15:0];
            if (idx == IDX_W'(IX_ENTRY))    entry_point  <= wdata[15:0];
         end
      end
   end

   for (genvar g = 0; g < int'(NUM_ATTR); g++) begin : g_attr
      logic [OFS_W-1:0]  ofs_q;
      logic [SIZE_W-1:0] size_q;
      logic [COMP_W-1:0] comp_q;
      logic              sel;

      assign sel = wr && in_attr && (grp == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ofs_q  <= '0;
            size_q <= '0;
            comp_q <= '0;
         end else if (sel) begin
            if (slot == IDX_W'(0)) ofs_q <= wdata[27:0];
            if (slot == IDX_W'(2)) begin
               size_q <= wdata[23:16];
               comp_q <= wdata[31:28];
            end
         end
      end

      assign attr_offset[g*OFS_W +: OFS_W]   = ofs_q;
      assign attr_size[g*SIZE_W +: SIZE_W]   = size_q;
      assign attr_comps[g*COMP_W +: COMP_W]  = comp_q;
   end
endmodule

// File: rtl/gpu_regbank.sv
module gpu_regbank
   import gpu_regbank_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR = 32'h1EF0_1000,
   parameter logic [31:0] WIN_BYTES = 32'h0000_0C00,
   parameter int unsigned NUM_REGS  = 64,
   parameter int unsigned NUM_ATTR  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [31:0]              bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [31:0]              bus_wdata,
   input  logic [31:0]              bus_wmask,
   output logic [31:0]              rd_data,
   output logic                     err_flag,
   output logic                     draw_pulse,
   output logic                     draw_indexed,
   output logic                     finalize_pulse,
   output logic [4:0]               attr_total,
   output logic [11:0]              fixed_mask,
   output logic [30:0]              color_base,
   output logic [30:0]              depth_base,
   output logic [2:0]               color_fmt,
   output logic [10:0]              fb_width,
   output logic [10:0]              fb_height,
   output logic [15:0]              bool_uniform,
   output logic [15:0]              entry_point,
   output logic [NUM_ATTR*28-1:0]   attr_offset,
   output logic [NUM_ATTR*8-1:0]    attr_size,
   output logic [NUM_ATTR*4-1:0]    attr_comps
);
   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (IX_ATTR_FIRST + ATTR_SLOTS*NUM_ATTR > NUM_REGS) begin : g_chk_attr
      $error("attribute groups exceed implemented register count");
   end
   if (NUM_REGS*4 > WIN_BYTES) begin : g_chk_win
      $error("implemented registers exceed the address window");
   end
   if (IX_XFER_END >= NUM_REGS) begin : g_chk_idx
      $error("decoded indices exceed implemented register count");
   end

   logic             in_win, in_range;
   logic [IDX_W-1:0] idx;

   gpu_regbank_dec #(
      .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES),
      .NUM_REGS(NUM_REGS),   .IDX_W(IDX_W)
   ) dec_i (
      .addr(bus_addr), .in_win(in_win), .in_range(in_range), .idx(idx)
   );

   gpu_regbank_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) store_i (
      .clk(clk), .rst_n(rst_n), .we(bus_wr), .re(bus_rd), .hit(in_range),
      .idx(idx), .wdata(bus_wdata), .wmask(bus_wmask), .rdata(rd_data)
   );

   gpu_regbank_side #(.NUM_ATTR(NUM_ATTR), .IDX_W(IDX_W)) side_i (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr && in_range), .idx(idx), .wdata(bus_wdata),
      .draw_pulse(draw_pulse), .draw_indexed(draw_indexed), .finalize_pulse(finalize_pulse),
      .attr_total(attr_total), .fixed_mask(fixed_mask),
      .color_base(color_base), .depth_base(depth_base), .color_fmt(color_fmt),
      .fb_width(fb_width), .fb_height(fb_height),
      .bool_uniform(bool_uniform), .entry_point(entry_point),
      .attr_offset(attr_offset), .attr_size(attr_size), .attr_comps(attr_comps)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_flag <= 1'b0;
      else if ((bus_wr || bus_rd) && in_win && !in_range) err_flag <= 1'b1;
   end
endmodule

// File: rtl/gpu_regbank_chk.sv
module gpu_regbank_chk #(
   parameter logic [31:0] BASE_ADDR = 32'h1EF0_1000,
   parameter logic [31:0] WIN_BYTES = 32'h0000_0C00
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] bus_addr,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [31:0] bus_wdata,
   input logic [31:0] rd_data,
   input logic        err_flag,
   input logic        draw_pulse,
   input logic        draw_indexed,
   input logic        finalize_pulse,
   input logic [4:0]  attr_total,
   input logic [11:0] fixed_mask
);
   logic outside;
   assign outside = (bus_addr < BASE_ADDR) || (bus_addr >= BASE_ADDR + WIN_BYTES);

   // R3
   a_r3_indexed_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      draw_indexed |-> draw_pulse);
   // R3
   a_r3_pulse_from_nonzero_write: assert property (@(posedge clk) disable iff (!rst_n)
      draw_pulse |-> ($past(bus_wr) && $past(bus_wdata) != 32'd0));
   // R9
   a_r9_finalize_from_nonzero_write: assert property (@(posedge clk) disable iff (!rst_n)
      finalize_pulse |-> ($past(bus_wr) && $past(bus_wdata) != 32'd0));
   // R10
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
   // R1
   a_r1_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && outside) |=> (rd_data == 32'd0));
   // R4
   a_r4_mask_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_total == 5'd0) |-> (fixed_mask == 12'd0));
endmodule

bind gpu_regbank gpu_regbank_chk #(.BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_wdata(bus_wdata), .rd_data(rd_data), .err_flag(err_flag),
   .draw_pulse(draw_pulse), .draw_indexed(draw_indexed), .finalize_pulse(finalize_pulse),
   .attr_total(attr_total), .fixed_mask(fixed_mask)
);

// File: tb/gpu_regbank_tb_top.sv
module gpu_regbank_tb_top;
   localparam int CLK_P = 10;
   localparam logic [31:0] BASE = 32'h1EF0_1000;
   localparam int NREG = 64;
   localparam int NATT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_wmask = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] rd_data;
   logic err_flag, draw_pulse, draw_indexed, finalize_pulse;
   logic [4:0] attr_total;
   logic [11:0] fixed_mask;
   logic [30:0] color_base, depth_base;
   logic [2:0] color_fmt;
   logic [10:0] fb_width, fb_height;
   logic [15:0] bool_uniform, entry_point;
   logic [NATT*28-1:0] attr_offset;
   logic [NATT*8-1:0] attr_size;
   logic [NATT*4-1:0] attr_comps;

   always #(CLK_P/2) clk = ~clk;

   gpu_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .rd_data(rd_data), .err_flag(err_flag),
      .draw_pulse(draw_pulse), .draw_indexed(draw_indexed), .finalize_pulse(finalize_pulse),
      .attr_total(attr_total), .fixed_mask(fixed_mask), .color_base(color_base),
      .depth_base(depth_base), .color_fmt(color_fmt), .fb_width(fb_width), .fb_height(fb_height),
      .bool_uniform(bool_uniform), .entry_point(entry_point),
      .attr_offset(attr_offset), .attr_size(attr_size), .attr_comps(attr_comps)
   );

   int n_checks = 0, n_fail = 0;

   // expected model
   logic [31:0] m_mem [NREG];
   logic [4:0]  m_total;  logic [11:0] m_fmask;
   logic [30:0] m_cbase, m_dbase; logic [2:0] m_cfmt;
   logic [10:0] m_w, m_h; logic [15:0] m_bool, m_entry;
   logic [27:0] m_ofs [NATT]; logic [7:0] m_size [NATT]; logic [3:0] m_comp [NATT];
   logic m_draw, m_indexed, m_fin, m_err;

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [31:0] m);
      return (o & ~m) | (d & m);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NREG; i++) m_mem[i] = '0;
      for (int g = 0; g < NATT; g++) begin m_ofs[g] = '0; m_size[g] = '0; m_comp[g] = '0; end
      m_total = '0; m_fmask = '0; m_cbase = '0; m_dbase = '0; m_cfmt = '0;
      m_w = '0; m_h = '0; m_bool = '0; m_entry = '0;
      m_draw = 0; m_indexed = 0; m_fin = 0; m_err = 0;
   endtask

   task automatic model_write(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m);
      int ix;
      m_draw = 0; m_indexed = 0; m_fin = 0;
      if (a < BASE || a >= BASE + 32'hC00) return;
      ix = int'((a - BASE) >> 2);
      if (ix >= NREG) begin m_err = 1; return; end
      m_mem[ix] = merge(m_mem[ix], d, m);
      case (ix)
         2: m_draw = (d != 0);
         3: begin m_draw = (d != 0); m_indexed = (d != 0); end
         4: begin m_total = 5'(d[31:28]) + 5'd1; m_fmask = d[27:16]; end
         8: m_cbase = {d[27:0], 3'b000};
         9: m_cfmt = d[18:16];
         10: m_dbase = {d[27:0], 3'b000};
         11: begin m_w = d[10:0]; m_h = 11'(d[21:12]) + 11'd1; end
         16: m_bool = d[15:0];
         17: m_entry = d[15:0];
         18: m_fin = (d != 0);
         default: if (ix >= 32 && ix < 32 + 3*NATT) begin
            if ((ix - 32) % 3 == 0) m_ofs[(ix - 32) / 3] = d[27:0];
            if ((ix - 32) % 3 == 2) begin
               m_size[(ix - 32) / 3] = d[23:16];
               m_comp[(ix - 32) / 3] = d[31:28];
            end
         end
      endcase
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d, m);
      chk("R3 draw_pulse", 128'(draw_pulse), 128'(m_draw));
      chk("R3 draw_indexed", 128'(draw_indexed), 128'(m_indexed));
      chk("R9 finalize_pulse", 128'(finalize_pulse), 128'(m_fin));
   endtask

   task automatic do_read(input logic [31:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      if (a >= BASE && a < BASE + 32'hC00 && ((a - BASE) >> 2) >= NREG) m_err = 1;
      v = rd_data;
   endtask

   task automatic check_sideband(input string tag);
      chk({tag, " R4 attr_total"}, 128'(attr_total), 128'(m_total));
      chk({tag, " R4 fixed_mask"}, 128'(fixed_mask), 128'(m_fmask));
      chk({tag, " R5 color_base"}, 128'(color_base), 128'(m_cbase));
      chk({tag, " R5 depth_base"}, 128'(depth_base), 128'(m_dbase));
      chk({tag, " R5 color_fmt"}, 128'(color_fmt), 128'(m_cfmt));
      chk({tag, " R6 fb_width"}, 128'(fb_width), 128'(m_w));
      chk({tag, " R6 fb_height"}, 128'(fb_height), 128'(m_h));
      chk({tag, " R8 bool_uniform"}, 128'(bool_uniform), 128'(m_bool));
      chk({tag, " R8 entry_point"}, 128'(entry_point), 128'(m_entry));
      for (int g = 0; g < NATT; g++) begin
         chk({tag, " R7 offset"}, 128'(attr_offset[g*28 +: 28]), 128'(m_ofs[g]));
         chk({tag, " R7 size"}, 128'(attr_size[g*8 +: 8]), 128'(m_size[g]));
         chk({tag, " R7 comps"}, 128'(attr_comps[g*4 +: 4]), 128'(m_comp[g]));
      end
      chk({tag, " R10 err_flag"}, 128'(err_flag), 128'(m_err));
   endtask

   task automatic check_all_words(input string tag);
      logic [31:0] v;
      for (int i = 0; i < NREG; i++) begin
         do_read(BASE + 32'(i*4), v);
         chk({tag, " R2 readback"}, 128'(v), 128'(m_mem[i]));
      end
   endtask

   function automatic logic [31:0] ra(input int ix);
      return BASE + 32'(ix*4);
   endfunction

   initial begin : watchdog
      #(CLK_P*150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      logic [31:0] v;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      check_sideband("R11 reset");
      chk("R11 draw_pulse", 128'(draw_pulse), 128'd0);
      do_read(ra(5), v);
      chk("R11 word after reset", 128'(v), 128'd0);

      // R2 masked merge
      do_write(ra(5), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      do_write(ra(5), 32'h0000_0000, 32'h0000_FFFF);
      do_read(ra(5), v);
      chk("R2 masked merge", 128'(v), 128'h FFFF_0000);

      // R3 draw triggers
      do_write(ra(2), 32'd0, 32'hFFFF_FFFF);
      do_write(ra(2), 32'd1, 32'hFFFF_FFFF);
      do_write(ra(3), 32'd0, 32'hFFFF_FFFF);
      do_write(ra(3), 32'h8000_0000, 32'h0);
      // R9 finalize
      do_write(ra(18), 32'd0, 32'hFFFF_FFFF);
      do_write(ra(18), 32'h10, 32'hFFFF_FFFF);

      // R12 zero mask still decodes
      do_write(ra(11), 32'h0015_5123, 32'h0);
      check_sideband("R12 zero mask");
      do_read(ra(11), v);
      chk("R12 stored word unchanged", 128'(v), 128'd0);

      // R6 height boundary
      do_write(ra(11), 32'h003F_F7FF, 32'hFFFF_FFFF);
      chk("R6 max height", 128'(fb_height), 128'd1024);

      // R1 out of window, aliasing fb index
      do_write(BASE + 32'h1000 + 32'h2C, 32'h0000_1001, 32'hFFFF_FFFF);
      do_write(BASE - 32'd4, 32'h1234_5678, 32'hFFFF_FFFF);
      check_sideband("R1 outside write");
      do_read(BASE + 32'hC00, v);
      chk("R1 outside read", 128'(v), 128'd0);
      do_read(BASE - 32'd4, v);
      chk("R1 below window read", 128'(v), 128'd0);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int ix;
         logic [31:0] d, m;
         ix = int'($urandom_range(0, NREG - 1));
         if (n % 3 == 0) ix = 32 + int'($urandom_range(0, 3*NATT - 1));
         d = $urandom();
         if (n % 5 == 0) d = 32'd0;
         m = (n % 4 == 0) ? 32'hFFFF_FFFF : $urandom();
         do_write(ra(ix), d, m);
      end
      check_sideband("random");
      check_all_words("random");

      // R10 bad index
      do_read(ra(63), v);
      chk("R10 last index readable", 128'(v), 128'(m_mem[63]));
      chk("R10 no error yet", 128'(err_flag), 128'd0);
      do_write(ra(64), 32'hDEAD_BEEF, 32'hFFFF_FFFF);
      chk("R10 error set", 128'(err_flag), 128'd1);
      do_read(ra(100), v);
      chk("R10 bad read zero", 128'(v), 128'd0);
      do_write(ra(17), 32'h0000_ABCD, 32'hFFFF_FFFF);
      check_sideband("R10 sticky");
      check_all_words("R10 no state change");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule